// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface Model

This block models the device side of a byte-wide parallel NOR flash. It watches an asynchronous bus made of chip select, output enable and write enable, all active low. It samples that bus with the system clock and turns each completed write cycle into one captured address and data pair. A sequence decoder checks those pairs against the software-protection unlock pattern. It then starts one of three internal operations: a byte program, an erase of one sector, or an erase of the whole array. The array is a small register file. A down-counter stands in for the program or erase time.

While an operation runs, every read returns a status byte in place of array data. Bit 7 carries the complement of bit 7 of the byte being written. Bit 6 flips after each finished read, so software can poll until two reads agree. Any bus writes made during that time are dropped. The parameter MEM_AW sets the array size. SECT_AW sets the sector size, and SECT_AW = 12 gives the 4 KByte sector of a full-size part. The three busy lengths are counts of clock cycles.

Top module: `pflash_cmd_ctrl`

The bus is not a stream: it has no valid/ready flow control. The host must respect the bus timing given below, and the block never stalls it.

## Requirements
- R1: After reset every array byte reads as FFh.
- R2: `rdata_en` is high only while chip select and output enable are both low, two clock samples back. A write cycle (output enable high) never raises it.
- R3: A write cycle lasts while chip select and write enable are both low. The address is the one present when the second of the two goes low. The data is the last value present before the first of the two goes high.
- R4: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then one write of address A and data D, programs byte A to (old AND D). Unlock addresses compare address bits [14:0].
- R5: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at address S sets to FFh every byte whose index bits [MEM_AW-1:SECT_AW] equal those of S. Other bytes do not change.
- R6: The same five-write prefix, then 10h at 5555h, sets every byte of the array to FFh.
- R7: A write whose address or data does not match the expected step returns the decoder to idle. The array does not change, and a later correct sequence still works.
- R8: While busy, a read returns {~D[7], T, 6'b0}. D is the program data, or FFh for an erase. T is 0 on the first read after the operation starts and flips after each completed read.
- R9: Writes made while an operation is busy are ignored, including complete command sequences.
- R10: An operation stays busy for PGM_CYC, SER_CYC or CER_CYC clock cycles and then returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Read output enable, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |
| rdata_en | output | 1 | Drive enable for rdata; low means the bus is released |

## Verification
The hardest case to reach is a complete, correctly formed command sequence that arrives while another operation is busy. It must leave no trace. The bench starts a sector erase and takes two status reads. It then writes a full program sequence aimed at a byte in another sector. Only after the erase has finished does it read that byte, expecting FFh. The toggle bit is checked by counting completed reads against the start of each operation.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {OP_PGM = 2'd0, OP_SERASE = 2'd1, OP_CERASE = 2'd2} op_e;

  localparam int          KEY_AW     = 15;
  localparam logic [14:0] KEY_ADR_A  = 15'h5555;
  localparam logic [14:0] KEY_ADR_B  = 15'h2AAA;
  localparam logic [7:0]  KEY_DAT_A  = 8'hAA;
  localparam logic [7:0]  KEY_DAT_B  = 8'h55;
  localparam logic [7:0]  CMD_PGM    = 8'hA0;
  localparam logic [7:0]  CMD_ESETUP = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
endpackage

// File: rtl/pflash_bus_sync.sv
module pflash_bus_sync #(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              rd_end,
  output logic [MEM_AW-1:0] rd_idx
);
  localparam int PW = 3 + ADDR_W + 8;

  logic [PW-1:0]     s1_q, s2_q;
  logic              cs2, oe2, we2;
  logic [ADDR_W-1:0] a2;
  logic [7:0]        d2;
  logic              wr_act, wr_act_q, rd_act_q;
  logic [ADDR_W-1:0] addr_lat_q;
  logic [7:0]        data_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= {3'b111, {(ADDR_W+8){1'b0}}};
      s2_q <= {3'b111, {(ADDR_W+8){1'b0}}};
    end else begin
      s1_q <= {chip_sel_n, out_en_n, wr_en_n, addr, wdata};
      s2_q <= s1_q;
    end
  end

  assign {cs2, oe2, we2, a2, d2} = s2_q;
  assign wr_act = ~cs2 & ~we2;
  assign rd_act = ~cs2 & ~oe2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q    <= 1'b0;
      rd_act_q    <= 1'b0;
      addr_lat_q  <= '0;
      data_hold_q <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act && !wr_act_q) addr_lat_q <= a2;
      if (wr_act) data_hold_q <= d2;
    end
  end

  assign wr_evt  = wr_act_q & ~wr_act;
  assign wr_addr = addr_lat_q;
  assign wr_data = data_hold_q;
  assign rd_end  = rd_act_q & ~rd_act;
  assign rd_idx  = a2[MEM_AW-1:0];

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_act_q) |=> $stable(addr_lat_q));
endmodule

// File: rtl/pflash_seq_dec.sv
module pflash_seq_dec
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              op_vld,
  output op_e               op_kind,
  output logic [MEM_AW-1:0] op_idx,
  output logic [7:0]        op_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3
  } seq_e;

  seq_e              state_q, state_d;
  logic              emit;
  op_e               kind_d;
  logic [KEY_AW-1:0] key;
  logic              hit_a, hit_b;

  assign key   = wr_addr[KEY_AW-1:0];
  assign hit_a = (key == KEY_ADR_A) && (wr_data == KEY_DAT_A);
  assign hit_b = (key == KEY_ADR_B) && (wr_data == KEY_DAT_B);

  always_comb begin
    state_d = state_q;
    emit    = 1'b0;
    kind_d  = OP_PGM;
    if (wr_evt) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: if (hit_a) state_d = S_U1;
        S_U1:   if (hit_b) state_d = S_U2;
        S_U2: begin
          if (key == KEY_ADR_A && wr_data == CMD_PGM)    state_d = S_PGM;
          if (key == KEY_ADR_A && wr_data == CMD_ESETUP) state_d = S_E1;
        end
        S_PGM:  emit = 1'b1;
        S_E1:   if (hit_a) state_d = S_E2;
        S_E2:   if (hit_b) state_d = S_E3;
        S_E3: begin
          if (wr_data == CMD_SECT) begin
            emit   = 1'b1;
            kind_d = OP_SERASE;
          end else if (wr_data == CMD_CHIP && key == KEY_ADR_A) begin
            emit   = 1'b1;
            kind_d = OP_CERASE;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_vld  <= 1'b0;
      op_kind <= OP_PGM;
      op_idx  <= '0;
      op_data <= '0;
    end else if (busy) begin
      state_q <= S_IDLE;
      op_vld  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_vld  <= emit;
      if (emit) begin
        op_kind <= kind_d;
        op_idx  <= wr_addr[MEM_AW-1:0];
        op_data <= (kind_d == OP_PGM) ? wr_data : 8'hFF;
      end
    end
  end

  // R9
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (state_q == S_IDLE && !op_vld));
endmodule

// File: rtl/pflash_exec.sv
module pflash_exec
  import pflash_pkg::*;
#(
  parameter int MEM_AW  = 6,
  parameter int SECT_AW = 4,
  parameter int PGM_CYC = 200,
  parameter int SER_CYC = 400,
  parameter int CER_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_vld,
  input  op_e               op_kind,
  input  logic [MEM_AW-1:0] op_idx,
  input  logic [7:0]        op_data,
  input  logic              rd_end,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic              busy,
  output logic [7:0]        rd_word,
  output logic [7:0]        stat_word
);
  localparam int DEPTH   = 1 << MEM_AW;
  localparam int MAX_AB  = (PGM_CYC > SER_CYC) ? PGM_CYC : SER_CYC;
  localparam int CNT_MAX = (MAX_AB > CER_CYC) ? MAX_AB : CER_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]            cnt_q;
  logic                        busy_q, tog_q, done;
  op_e                         kind_q;
  logic [MEM_AW-1:0]           idx_q;
  logic [7:0]                  dat_q;
  logic [DEPTH-1:0][7:0]       mem_w;

  assign done = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PGM;
      idx_q  <= '0;
      dat_q  <= 8'hFF;
      tog_q  <= 1'b0;
    end else if (!busy_q) begin
      if (op_vld) begin
        busy_q <= 1'b1;
        kind_q <= op_kind;
        idx_q  <= op_idx;
        dat_q  <= op_data;
        tog_q  <= 1'b0;
        unique case (op_kind)
          OP_PGM:    cnt_q <= CNT_W'(PGM_CYC);
          OP_SERASE: cnt_q <= CNT_W'(SER_CYC);
          default:   cnt_q <= CNT_W'(CER_CYC);
        endcase
      end
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (rd_end) tog_q <= ~tog_q;
      if (done) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [MEM_AW-1:0] GA = MEM_AW'(g);
    logic [7:0] word_q;
    logic       hit;
    assign hit = done && ((kind_q == OP_CERASE) ||
                 (kind_q == OP_SERASE && GA[MEM_AW-1:SECT_AW] == idx_q[MEM_AW-1:SECT_AW]) ||
                 (kind_q == OP_PGM && GA == idx_q));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= 8'hFF;
      else if (hit) word_q <= (kind_q == OP_PGM) ? (word_q & dat_q) : 8'hFF;
    end
    assign mem_w[g] = word_q;
  end

  assign busy      = busy_q;
  assign rd_word   = mem_w[rd_idx];
  assign stat_word = {~dat_q[7], tog_q, 6'b000000};

  // R10
  run_to_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > CNT_W'(1)) |=> busy_q);
  // R9
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_vld) |=> ($stable(kind_q) && $stable(idx_q) && $stable(dat_q)));
  // R4
  pgm_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_q == OP_PGM) |=> ((mem_w[idx_q] & ~$past(mem_w[idx_q])) == 8'h00));
  // R6
  chip_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_q == OP_CERASE) |=> (&mem_w));
endmodule

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int MEM_AW  = 6,
  parameter int SECT_AW = 4,
  parameter int PGM_CYC = 200,
  parameter int SER_CYC = 400,
  parameter int CER_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_en
);
  logic              wr_evt, rd_act, rd_end, busy, op_vld;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data, op_data, rd_word, stat_word;
  logic [MEM_AW-1:0] rd_idx, op_idx;
  op_e               op_kind;

  pflash_bus_sync #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_sync (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata), .wr_evt(wr_evt),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_act(rd_act), .rd_end(rd_end),
    .rd_idx(rd_idx)
  );

  pflash_seq_dec #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .op_vld(op_vld), .op_kind(op_kind),
    .op_idx(op_idx), .op_data(op_data)
  );

  pflash_exec #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .PGM_CYC(PGM_CYC),
                .SER_CYC(SER_CYC), .CER_CYC(CER_CYC)) u_exec (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_kind(op_kind),
    .op_idx(op_idx), .op_data(op_data), .rd_end(rd_end), .rd_idx(rd_idx),
    .busy(busy), .rd_word(rd_word), .stat_word(stat_word)
  );

  assign rdata    = busy ? stat_word : rd_word;
  assign rdata_en = rd_act;

  // R2
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_en |-> (!$past(chip_sel_n, 2) && !$past(out_en_n, 2)));
endmodule

// File: tb/pflash_cmd_ctrl_tb.sv
module pflash_cmd_ctrl_tb;
  localparam int PGM = 200, SER = 400, CER = 600;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        chip_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_en;
  int          n_chk = 0, n_err = 0;
  bit          ended = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] obs_q[$];

  always #4 clk = ~clk;

  pflash_cmd_ctrl #(.PGM_CYC(PGM), .SER_CYC(SER), .CER_CYC(CER)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d);
    addr = a; wdata = d; chip_sel_n = 1'b0;
    tick(2); wr_en_n = 1'b0;
    tick(4); wr_en_n = 1'b1;
    tick(2); chip_sel_n = 1'b1;
    tick(3);
  endtask

  // R3: junk address before the strobe, junk data early and after the capture points
  task automatic wr_skew(logic [14:0] a, logic [7:0] d);
    addr = 15'h0033; wdata = 8'h00; chip_sel_n = 1'b0;
    tick(3); addr = a;
    tick(1); wr_en_n = 1'b0;
    tick(3); addr = 15'h003E;
    tick(1); wdata = d;
    tick(3); wr_en_n = 1'b1;
    tick(1); wdata = 8'h00;
    tick(2); chip_sel_n = 1'b1;
    tick(3);
  endtask

  task automatic rd(logic [14:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; chip_sel_n = 1'b0; out_en_n = 1'b0;
    tick(5);
    obs_q.push_back({rdata_en, rdata});
    out_en_n = 1'b1; chip_sel_n = 1'b1;
    tick(4);
  endtask

  task automatic unlock(logic [7:0] cmd);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, cmd);
  endtask

  task automatic prog(logic [14:0] a, logic [7:0] d);
    unlock(8'hA0); wr(a, d);
  endtask

  task automatic erase_prefix();
    unlock(8'h80); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [8:0] o;
      logic [7:0] e;
      string      t;
      o = obs_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(o == {1'b1, e}, t, o, {1'b1, e});
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(3);
    chk(rdata_en == 1'b0, "R2 idle release", {8'h0, rdata_en}, 9'h0);
    rd(15'h0000, 8'hFF, "R1 reset byte 0");
    rd(15'h002A, 8'hFF, "R1 reset byte 2A");

    // R2: one enable alone does not drive
    chip_sel_n = 1'b0; tick(5);
    chk(rdata_en == 1'b0, "R2 select only", {8'h0, rdata_en}, 9'h0);
    chip_sel_n = 1'b1; out_en_n = 1'b0; tick(5);
    chk(rdata_en == 1'b0, "R2 oe only", {8'h0, rdata_en}, 9'h0);
    out_en_n = 1'b1; tick(3);

    // R4 / R8 / R10: program 5A at 03
    prog(15'h0003, 8'h5A);
    rd(15'h0003, 8'h80, "R8 poll1 dq7=~0 t=0");
    rd(15'h0003, 8'hC0, "R8 poll2 t=1");
    tick(100);
    rd(15'h0003, 8'h80, "R10 still busy mid program");
    tick(PGM);
    rd(15'h0003, 8'h5A, "R4 program 5A");

    // R4: second program ANDs with old value
    prog(15'h0003, 8'h0F);
    tick(PGM + 20);
    rd(15'h0003, 8'h0A, "R4 and with old");

    // R8: bit7 of data set gives dq7 = 0
    prog(15'h0011, 8'hF0);
    rd(15'h0011, 8'h00, "R8 dq7=~1");
    tick(PGM + 20);
    rd(15'h0011, 8'hF0, "R4 program F0");

    // R3: capture points of address and data
    unlock(8'hA0); wr_skew(15'h0007, 8'h3C);
    tick(PGM + 20);
    rd(15'h0007, 8'h3C, "R3 skewed write");
    rd(15'h0033, 8'hFF, "R3 early addr untouched");
    rd(15'h003E, 8'hFF, "R3 late addr untouched");

    // R7: broken sequences, then recovery
    wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'hA0); wr(15'h0008, 8'h00);
    tick(PGM + 20);
    rd(15'h0008, 8'hFF, "R7 bad step addr");
    wr(15'h5555, 8'hAB); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0); wr(15'h0008, 8'h00);
    tick(PGM + 20);
    rd(15'h0008, 8'hFF, "R7 bad step data");
    prog(15'h0008, 8'h81);
    tick(PGM + 20);
    rd(15'h0008, 8'h81, "R7 recovers");

    // R5 / R9: sector erase of sector 0 (bytes 00-0F), program attempt during it
    erase_prefix(); wr(15'h0005, 8'h30);
    rd(15'h0000, 8'h00, "R8 erase poll t=0");
    rd(15'h0000, 8'h40, "R8 erase poll t=1");
    prog(15'h0022, 8'h00);
    tick(SER);
    rd(15'h0003, 8'hFF, "R5 sector byte 03");
    rd(15'h0007, 8'hFF, "R5 sector byte 07");
    rd(15'h0008, 8'hFF, "R5 sector byte 08");
    rd(15'h0011, 8'hF0, "R5 other sector kept");
    rd(15'h0022, 8'hFF, "R9 busy program ignored");

    // R6: chip erase
    prog(15'h003F, 8'h12);
    tick(PGM + 20);
    rd(15'h003F, 8'h12, "R4 program 3F");
    erase_prefix(); wr(15'h5555, 8'h10);
    rd(15'h0000, 8'h00, "R8 chip poll");
    tick(CER);
    rd(15'h0011, 8'hFF, "R6 byte 11");
    rd(15'h003F, 8'hFF, "R6 byte 3F");

    tick(10);
    finish_run();
  end
endmodule